// File: doc/BRIEF.md
# Arrival-Order Predicate Prefix Scan

This block gives each warp that arrives at a named barrier an exclusive prefix count of true thread predicates. It counts every qualifying thread that reached the same barrier name earlier, and it leaves out the arriving warp's own threads. Each arrival presents a barrier name, a lane activity mask, a lane predicate mask and an invert flag. The warp's contribution is the number of active lanes whose predicate is true once the optional complement is applied. The block records the prefix for the warp, then adds the contribution to that barrier's running total. The requester is never held back: every warp may arrive in every cycle, and there is no handshake.

A running total is kept for each barrier name. An external completion strobe clears the total for one name, so the barrier can be reused in the cycle that follows. When several warps arrive in one cycle, they are ordered by ascending warp index. The prefix each warp receives is stored in a per-warp result register. Software reads these registers back through a single indexed read port, and must read a warp's value before that warp arrives again.

Top module: `arrival_prefix_scan`

## Requirements
- R1: After reset, every result register reads 0 and every barrier's running total is 0.
- R2: A warp's contribution equals the population count of `arr_active & (arr_pred ^ {LANES{arr_invert}})`. Inactive lanes never add to a total, whatever their predicate.
- R3: An arriving warp's result register is loaded with the running total of its barrier as it stood before the warp's own contribution (an exclusive prefix). The value is readable on `rd_prefix` after the clock edge that samples the arrival.
- R4: After each arrival, the barrier's running total grows by exactly the warp's contribution.
- R5: When several warps arrive on the same barrier in one cycle, a lower warp index counts as arriving earlier. Each warp's prefix includes the contributions of the lower-indexed warps in that cycle.
- R6: Arrivals on one barrier name leave the running totals of all other names unchanged.
- R7: A completion strobe (`done_valid` with `done_bar`) sets that barrier's running total to 0. If an arrival on the same barrier occurs in the same cycle, the clear takes effect first: the arrival sees a prefix of 0, and the total becomes the arrival's contribution.
- R8: A warp's result register holds its value until that same warp arrives again. Arrivals by other warps do not change it.
- R9: Arrivals are accepted in every cycle, back to back, from any set of warps, with no stall or backpressure.
- R10: Running totals and prefixes wrap modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arr_valid | input | WARPS | One arrival strobe per warp |
| arr_bar | input | WARPS x log2(BARS) | Barrier name for each warp's arrival |
| arr_active | input | WARPS x LANES | Active lane mask for each warp |
| arr_pred | input | WARPS x LANES | Lane predicate mask for each warp |
| arr_invert | input | WARPS | Complement the predicates before counting |
| done_valid | input | 1 | Completion strobe that clears one barrier total |
| done_bar | input | log2(BARS) | Barrier name cleared by the strobe |
| rd_warp | input | log2(WARPS) | Warp index selected on the read port |
| rd_prefix | output | CNT_W | Result register of the selected warp |

## Verification
The internal checks assume that `rst_n` is held low for at least two clock edges. They also assume that `arr_bar` and `done_bar` name barriers below BARS, and that the order-consistency check runs only when a full cycle of arrivals cannot wrap the count width. The stimulus changes every input on the falling clock edge. It picks barrier names only from the legal range, and it gives long runs of full-lane arrivals only to the wrap test, where the default widths allow the order check. Because the read port is combinational, the results are read after each rising edge, one warp at a time.

// File: rtl/arrival_scan_pkg.sv
package arrival_scan_pkg;

  localparam int unsigned DEF_WARPS = 8;
  localparam int unsigned DEF_LANES = 32;
  localparam int unsigned DEF_BARS  = 16;
  localparam int unsigned DEF_CNT_W = 12;

endpackage

// File: rtl/aps_lane_count.sv
module aps_lane_count #(
  parameter int unsigned LANES = 32,
  parameter int unsigned CW    = 6
) (
  input  logic [LANES-1:0] active,
  input  logic [LANES-1:0] pred,
  input  logic             invert,
  output logic [CW-1:0]    count
);

  logic [LANES-1:0] qual;

  always_comb begin
    qual  = active & (pred ^ {LANES{invert}});
    count = '0;
    for (int i = 0; i < int'(LANES); i++) begin
      if (qual[i]) count = count + CW'(1);
    end
  end

endmodule

// File: rtl/aps_order_net.sv
module aps_order_net #(
  parameter int unsigned WARPS = 8,
  parameter int unsigned BARS  = 16,
  parameter int unsigned BAR_W = 4,
  parameter int unsigned CW    = 12
) (
  input  logic [WARPS-1:0]            valid,
  input  logic [WARPS-1:0][BAR_W-1:0] bar,
  input  logic [WARPS-1:0][CW-1:0]    cnt,
  output logic [WARPS-1:0][CW-1:0]    intra,
  output logic [BARS-1:0][CW-1:0]     bar_add,
  output logic [BARS-1:0]             bar_hit
);

  // earlier same-cycle arrivals on the same name, lower index first
  always_comb begin
    for (int w = 0; w < int'(WARPS); w++) begin
      intra[w] = '0;
      for (int j = 0; j < int'(WARPS); j++) begin
        if (j < w && valid[j] && bar[j] == bar[w]) begin
          intra[w] = intra[w] + cnt[j];
        end
      end
    end
  end

  // total added to each name in this cycle
  always_comb begin
    for (int b = 0; b < int'(BARS); b++) begin
      bar_add[b] = '0;
      bar_hit[b] = 1'b0;
      for (int w = 0; w < int'(WARPS); w++) begin
        if (valid[w] && bar[w] == BAR_W'(b)) begin
          bar_add[b] = bar_add[b] + cnt[w];
          bar_hit[b] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/aps_sum_bank.sv
module aps_sum_bank #(
  parameter int unsigned BARS  = 16,
  parameter int unsigned BAR_W = 4,
  parameter int unsigned CW    = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_valid,
  input  logic [BAR_W-1:0]        clr_bar,
  input  logic [BARS-1:0]         bar_hit,
  input  logic [BARS-1:0][CW-1:0] bar_add,
  output logic [BARS-1:0][CW-1:0] base
);

  logic [BARS-1:0][CW-1:0] sum_q;
  logic [BARS-1:0][CW-1:0] sum_d;
  logic [BARS-1:0]         sum_en;
  logic [BARS-1:0]         clr_sel;

  always_comb begin
    for (int b = 0; b < int'(BARS); b++) begin
      clr_sel[b] = clr_valid && (clr_bar == BAR_W'(b));
      base[b]    = clr_sel[b] ? '0 : sum_q[b];
      sum_en[b]  = clr_sel[b] || bar_hit[b];
      sum_d[b]   = base[b] + bar_add[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else begin
      for (int b = 0; b < int'(BARS); b++) begin
        if (sum_en[b]) sum_q[b] <= sum_d[b];
      end
    end
  end

  for (genvar g = 0; g < int'(BARS); g++) begin : g_chk
    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_valid && clr_bar == BAR_W'(g) && !bar_hit[g]) |=> (sum_q[g] == '0));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(clr_valid && clr_bar == BAR_W'(g)) && !bar_hit[g]) |=> $stable(sum_q[g]));
  end

endmodule

// File: rtl/aps_result_file.sv
module aps_result_file #(
  parameter int unsigned WARPS = 8,
  parameter int unsigned WID_W = 3,
  parameter int unsigned CW    = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WARPS-1:0]         load,
  input  logic [WARPS-1:0][CW-1:0] load_val,
  input  logic [WID_W-1:0]         rd_idx,
  output logic [CW-1:0]            rd_data
);

  logic [WARPS-1:0][CW-1:0] res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else begin
      for (int w = 0; w < int'(WARPS); w++) begin
        if (load[w]) res_q[w] <= load_val[w];
      end
    end
  end

  always_comb begin
    rd_data = res_q[rd_idx];
  end

  for (genvar g = 0; g < int'(WARPS); g++) begin : g_chk
    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load[g] |=> $stable(res_q[g]));
  end

endmodule

// File: rtl/arrival_prefix_scan.sv
module arrival_prefix_scan
  import arrival_scan_pkg::*;
#(
  parameter int unsigned WARPS = DEF_WARPS,
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned BARS  = DEF_BARS,
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [WARPS-1:0]                     arr_valid,
  input  logic [WARPS-1:0][$clog2(BARS)-1:0]   arr_bar,
  input  logic [WARPS-1:0][LANES-1:0]          arr_active,
  input  logic [WARPS-1:0][LANES-1:0]          arr_pred,
  input  logic [WARPS-1:0]                     arr_invert,
  input  logic                                 done_valid,
  input  logic [$clog2(BARS)-1:0]              done_bar,
  input  logic [$clog2(WARPS)-1:0]             rd_warp,
  output logic [CNT_W-1:0]                     rd_prefix
);

  localparam int unsigned BAR_W   = $clog2(BARS);
  localparam int unsigned WID_W   = $clog2(WARPS);
  localparam int unsigned LANE_CW = $clog2(LANES + 1);
  localparam bit          NO_WRAP = (WARPS * LANES) < (2 ** CNT_W);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [WARPS-1:0][LANE_CW-1:0] lane_cnt;
  logic [WARPS-1:0][CNT_W-1:0]   cnt_ext;
  logic [WARPS-1:0][CNT_W-1:0]   intra;
  logic [BARS-1:0][CNT_W-1:0]    bar_add;
  logic [BARS-1:0]               bar_hit;
  logic [BARS-1:0][CNT_W-1:0]    base;
  logic [WARPS-1:0][CNT_W-1:0]   prefix_val;

  for (genvar w = 0; w < int'(WARPS); w++) begin : g_lane
    aps_lane_count #(
      .LANES (LANES),
      .CW    (LANE_CW)
    ) u_cnt (
      .active (arr_active[w]),
      .pred   (arr_pred[w]),
      .invert (arr_invert[w]),
      .count  (lane_cnt[w])
    );
    assign cnt_ext[w] = CNT_W'(lane_cnt[w]);

    // R2
    lane_bound_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      int'(lane_cnt[w]) <= $countones(arr_active[w]));
  end

  aps_order_net #(
    .WARPS (WARPS),
    .BARS  (BARS),
    .BAR_W (BAR_W),
    .CW    (CNT_W)
  ) u_order (
    .valid   (arr_valid),
    .bar     (arr_bar),
    .cnt     (cnt_ext),
    .intra   (intra),
    .bar_add (bar_add),
    .bar_hit (bar_hit)
  );

  aps_sum_bank #(
    .BARS  (BARS),
    .BAR_W (BAR_W),
    .CW    (CNT_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_valid (done_valid),
    .clr_bar   (done_bar),
    .bar_hit   (bar_hit),
    .bar_add   (bar_add),
    .base      (base)
  );

  always_comb begin
    for (int w = 0; w < int'(WARPS); w++) begin
      prefix_val[w] = base[arr_bar[w]] + intra[w];
    end
  end

  aps_result_file #(
    .WARPS (WARPS),
    .WID_W (WID_W),
    .CW    (CNT_W)
  ) u_res (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (arr_valid),
    .load_val (prefix_val),
    .rd_idx   (rd_warp),
    .rd_data  (rd_prefix)
  );

  if (NO_WRAP) begin : g_order_chk
    for (genvar w = 0; w < int'(WARPS); w++) begin : g_w
      // R5
      order_fits_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        arr_valid[w] |-> ({1'b0, intra[w]} + {1'b0, cnt_ext[w]} <= {1'b0, bar_add[arr_bar[w]]}));
    end
  end

endmodule

// File: tb/arrival_prefix_scan_test.sv
module arrival_prefix_scan_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int  W   = 8;
  localparam int  L   = 32;
  localparam int  NB  = 16;
  localparam int  CW  = 12;
  localparam real CLK_PERIOD = 20.0;

  logic                  clk;
  logic                  rst_n;
  logic [W-1:0]          arr_valid;
  logic [W-1:0][3:0]     arr_bar;
  logic [W-1:0][L-1:0]   arr_active;
  logic [W-1:0][L-1:0]   arr_pred;
  logic [W-1:0]          arr_invert;
  logic                  done_valid;
  logic [3:0]            done_bar;
  logic [2:0]            rd_warp;
  logic [CW-1:0]         rd_prefix;

  // staging for the next cycle
  logic [W-1:0]          s_v;
  logic [W-1:0][3:0]     s_b;
  logic [W-1:0][L-1:0]   s_a;
  logic [W-1:0][L-1:0]   s_p;
  logic [W-1:0]          s_i;
  logic                  s_dv;
  logic [3:0]            s_db;

  logic [CW-1:0] exp_sum [NB];
  logic [CW-1:0] exp_res [W];

  int checks = 0;
  int errors = 0;

  arrival_prefix_scan uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .arr_valid  (arr_valid),
    .arr_bar    (arr_bar),
    .arr_active (arr_active),
    .arr_pred   (arr_pred),
    .arr_invert (arr_invert),
    .done_valid (done_valid),
    .done_bar   (done_bar),
    .rd_warp    (rd_warp),
    .rd_prefix  (rd_prefix)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2.0) clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): got hung run, expected completion");
    summary();
    $finish;
  end

  task automatic clear_stage();
    s_v = '0; s_b = '0; s_a = '0; s_p = '0; s_i = '0; s_dv = 1'b0; s_db = '0;
  endtask

  task automatic add_arr(input int w, input int b, input logic [L-1:0] a,
                         input logic [L-1:0] p, input logic inv);
    s_v[w] = 1'b1; s_b[w] = 4'(b); s_a[w] = a; s_p[w] = p; s_i[w] = inv;
  endtask

  task automatic read_all(input string tag);
    for (int w = 0; w < W; w++) begin
      rd_warp = 3'(w);
      #0.5;
      checks++;
      if (rd_prefix !== exp_res[w]) begin
        errors++;
        $display("FAIL %s warp %0d: got %0d expected %0d", tag, w, rd_prefix, exp_res[w]);
      end
    end
  endtask

  // called on a falling edge; returns on the next falling edge
  task automatic step(input string tag);
    arr_valid = s_v; arr_bar = s_b; arr_active = s_a; arr_pred = s_p;
    arr_invert = s_i; done_valid = s_dv; done_bar = s_db;
    if (s_dv) exp_sum[s_db] = '0;
    for (int w = 0; w < W; w++) begin
      if (s_v[w]) begin
        exp_res[w] = exp_sum[s_b[w]];
        exp_sum[s_b[w]] = exp_sum[s_b[w]] +
          CW'($countones(s_a[w] & (s_i[w] ? ~s_p[w] : s_p[w])));
      end
    end
    @(posedge clk);
    #1;
    arr_valid = '0; done_valid = 1'b0;
    read_all(tag);
    @(negedge clk);
    clear_stage();
  endtask

  // empty-mask arrival by warp 0 exposes a barrier total
  task automatic probe(input int b, input string tag);
    clear_stage();
    add_arr(0, b, '0, '1, 1'b0);
    step(tag);
  endtask

  initial begin
    rst_n = 1'b0;
    arr_valid = '0; arr_bar = '0; arr_active = '0; arr_pred = '0;
    arr_invert = '0; done_valid = 1'b0; done_bar = '0; rd_warp = '0;
    clear_stage();
    for (int b = 0; b < NB; b++) exp_sum[b] = '0;
    for (int w = 0; w < W; w++) exp_res[w] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state of results and totals
    #1;
    read_all("R1");
    @(negedge clk);
    for (int b = 0; b < NB; b++) probe(b, "R1");

    // R2: sweep active width and invert on one warp, totals seen by later arrivals
    for (int n = 0; n <= L; n++) begin
      for (int inv = 0; inv < 2; inv++) begin
        clear_stage();
        add_arr(2, 3, (n == L) ? '1 : ((L'(1) << n) - L'(1)), 32'h5555_5555 ^ 32'(n), inv[0]);
        step("R2");
      end
    end
    probe(3, "R2");

    // R3 R4: single warps arriving one after another on one name
    for (int w = 0; w < W; w++) begin
      clear_stage();
      add_arr(w, 7, '1, 32'(w * 37 + 1), 1'b0);
      step("R3");
    end
    probe(7, "R4");

    // R5: all warps in one cycle on one name, distinct counts
    clear_stage();
    for (int w = 0; w < W; w++) add_arr(w, 2, (L'(1) << (w + 1)) - L'(1), '1, 1'b0);
    step("R5");
    probe(2, "R5");

    // R6: mixed names in one cycle
    clear_stage();
    for (int w = 0; w < W; w++) add_arr(w, 10 + (w % 3), '1, 32'h0F0F_00FF, w[0]);
    step("R6");
    for (int b = 9; b < 14; b++) probe(b, "R6");

    // R7: clear alone, then clear with a same-cycle arrival
    clear_stage(); s_dv = 1'b1; s_db = 4'd10; step("R7");
    probe(10, "R7");
    clear_stage(); s_dv = 1'b1; s_db = 4'd11;
    add_arr(4, 11, '1, 32'h0000_00FF, 1'b0);
    add_arr(6, 11, '1, 32'h0000_0003, 1'b0);
    step("R7");
    probe(11, "R7");

    // R8: others arrive while warp 5 holds its value
    clear_stage(); add_arr(5, 12, '1, '1, 1'b0); step("R8");
    for (int k = 0; k < 4; k++) begin
      clear_stage();
      add_arr(1, 12, '1, '1, 1'b0);
      add_arr(7, 12, '1, '0, 1'b1);
      step("R8");
    end

    // R9: one warp arriving every cycle
    for (int k = 0; k < 6; k++) begin
      clear_stage();
      add_arr(3, 13, 32'hFFFF_0000, 32'(k) * 32'h0101_0101, 1'b0);
      step("R9");
    end

    // R10: drive one name past 2^CW
    for (int k = 0; k < 18; k++) begin
      clear_stage();
      for (int w = 0; w < W; w++) add_arr(w, 9, '1, '1, 1'b0);
      step("R10");
    end
    probe(9, "R10");

    // R3 R4 R5: sweep of random traffic on a few names with clears
    for (int k = 0; k < 1500; k++) begin
      clear_stage();
      for (int w = 0; w < W; w++) begin
        if ($urandom_range(1, 0) == 1)
          add_arr(w, $urandom_range(3, 0), $urandom, $urandom, 1'($urandom_range(1, 0)));
      end
      if ($urandom_range(15, 0) == 0) begin
        s_dv = 1'b1;
        s_db = 4'($urandom_range(3, 0));
      end
      step("R3 R4 R5");
    end

    summary();
    $finish;
  end

endmodule